// File: doc/BRIEF.md
# Physical Register Readiness Scoreboard

This block keeps one readiness bit for every physical register of an out-of-order core. Integer and floating-point registers share one index space: the integer registers come first, and the floating-point registers follow directly after them. With the default sizes, tags 0 to 95 name integer registers and tags 96 to 191 name floating-point registers. A bit value of 1 means the register's value has been produced, or has just been woken. A bit value of 0 means a producer is still outstanding and consumers must wait for it.

The rename stage drives the allocation port when it assigns a register as a destination, and this clears the bit. The completion port broadcasts the tag of a register whose value has arrived, and this sets the bit. The same event appears one cycle later as a single bit in a wakeup vector. Each waiting-consumer group is indexed by register number, so that bit position selects which group to wake. Several independent read ports return the readiness of the source tags that the issue logic presents. Each read sees the state after that cycle's updates, so a completion in the same cycle reaches the reader without delay.

Top module: `phys_reg_scoreboard`

## Requirements
- R1: After synchronous reset every register reads ready (1), the wakeup vector is all zero and the error output is 0.
- R2: An in-range allocation of tag T makes later reads of T return 0 until a completion for T arrives.
- R3: An in-range completion of tag T makes later reads of T return 1.
- R4: A read whose tag equals the completion tag in the same cycle returns 1 (completion bypass); a read whose tag equals the allocation tag in the same cycle returns 0.
- R5: When allocation and completion name the same tag in one cycle, the allocation wins: the bit becomes 0 and no wakeup bit is raised.
- R6: The cycle after an in-range completion of tag T (not overridden by R5), wake_vec has exactly bit T set; in every other case wake_vec is all zero.
- R7: Any valid allocation, completion or read whose tag is at or above INT_REGS+FP_REGS has no effect on stored state, and tag_err is 1 in the following cycle. tag_err is 0 after a cycle with no such access. Tag 191 is the last valid tag with the default sizes, and tag 192 is the first invalid one.
- R8: Each read port p returns its result on rd_ready[p] one cycle after rd_vld[p] and its tag, independently of the other ports. An idle or out-of-range read returns 0. Port p's tag occupies rd_tags[p*TAG_W +: TAG_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Destination allocation strobe |
| alloc_tag | input | TAG_W | Tag of the newly allocated destination |
| done_vld | input | 1 | Completion broadcast strobe |
| done_tag | input | TAG_W | Tag whose value has been produced |
| rd_vld | input | N_READ | Per-port read strobe |
| rd_tags | input | N_READ*TAG_W | Packed source tags, port p at bits p*TAG_W +: TAG_W |
| rd_ready | output | N_READ | Registered readiness per read port |
| wake_vec | output | INT_REGS+FP_REGS | Registered one-hot wakeup vector |
| tag_err | output | 1 | Registered out-of-range tag flag |

## Verification
A bit stuck or wrongly flipped in the state array shows up on the first read of that tag. This happens one cycle after the read is presented, and at the latest when randomized traffic next names that register. A wrong bypass or alloc-over-completion priority shows up only in cycles where two ports share a tag, so the stimulus forces such collisions deliberately and also lets them occur at random. An out-of-range access that leaks into state shows up as a wrong read of the aliased low bits, and it also shows up at once on tag_err in the next cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // update applied to one readiness bit in a cycle
  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_READY   = 2'd1,
    UPD_PENDING = 2'd2
  } sb_upd_e;

  function automatic sb_upd_e pick_update(input logic alloc_hit, input logic done_hit);
    if (alloc_hit)     return UPD_PENDING;
    else if (done_hit) return UPD_READY;
    else               return UPD_HOLD;
  endfunction
endpackage

// File: rtl/sb_tag_decode.sv
module sb_tag_decode #(
  parameter int TOTAL = 192,
  parameter int TAG_W = 8
) (
  input  logic             vld,
  input  logic [TAG_W-1:0] tag,
  output logic [TOTAL-1:0] hot,
  output logic             bad
);
  localparam logic [TAG_W:0] LIMIT = TOTAL[TAG_W:0];

  logic in_range;
  assign in_range = ({1'b0, tag} < LIMIT);
  assign bad      = vld && !in_range;

  for (genvar i = 0; i < TOTAL; i++) begin : g_hot
    assign hot[i] = vld && (tag == TAG_W'(i));
  end
endmodule

// File: rtl/sb_state_array.sv
module sb_state_array
  import sb_pkg::*;
#(
  parameter int TOTAL = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] alloc_hot,
  input  logic [TOTAL-1:0] done_hot,
  output logic [TOTAL-1:0] state_q,
  output logic [TOTAL-1:0] state_nx
);
  for (genvar i = 0; i < TOTAL; i++) begin : g_bit
    sb_upd_e upd;
    always_comb begin
      upd = pick_update(alloc_hot[i], done_hot[i]);
      unique case (upd)
        UPD_PENDING: state_nx[i] = 1'b0;
        UPD_READY:   state_nx[i] = 1'b1;
        default:     state_nx[i] = state_q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) state_q[i] <= 1'b1;
      else     state_q[i] <= state_nx[i];
    end
  end
endmodule

// File: rtl/sb_read_port.sv
module sb_read_port #(
  parameter int TOTAL = 192,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [TAG_W-1:0] tag,
  input  logic [TOTAL-1:0] state_nx,
  output logic             ready_q,
  output logic             bad
);
  localparam logic [TAG_W:0] LIMIT = TOTAL[TAG_W:0];

  logic in_range;
  assign in_range = ({1'b0, tag} < LIMIT);
  assign bad      = vld && !in_range;

  always_ff @(posedge clk) begin
    if (rst)                  ready_q <= 1'b0;
    else if (vld && in_range) ready_q <= state_nx[tag];
    else                      ready_q <= 1'b0;
  end
endmodule

// File: rtl/phys_reg_scoreboard.sv
module phys_reg_scoreboard #(
  parameter int INT_REGS = 96,
  parameter int FP_REGS  = 96,
  parameter int N_READ   = 2,
  localparam int TOTAL   = INT_REGS + FP_REGS,
  localparam int TAG_W   = $clog2(TOTAL)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_vld,
  input  logic [TAG_W-1:0]        alloc_tag,
  input  logic                    done_vld,
  input  logic [TAG_W-1:0]        done_tag,
  input  logic [N_READ-1:0]       rd_vld,
  input  logic [N_READ*TAG_W-1:0] rd_tags,
  output logic [N_READ-1:0]       rd_ready,
  output logic [TOTAL-1:0]        wake_vec,
  output logic                    tag_err
);
  logic [TOTAL-1:0]  alloc_hot, done_hot;
  logic              alloc_bad, done_bad;
  logic [TOTAL-1:0]  state_q, state_nx;
  logic [N_READ-1:0] rd_bad;

  sb_tag_decode #(.TOTAL(TOTAL), .TAG_W(TAG_W)) u_alloc_dec (
    .vld(alloc_vld), .tag(alloc_tag), .hot(alloc_hot), .bad(alloc_bad)
  );

  sb_tag_decode #(.TOTAL(TOTAL), .TAG_W(TAG_W)) u_done_dec (
    .vld(done_vld), .tag(done_tag), .hot(done_hot), .bad(done_bad)
  );

  sb_state_array #(.TOTAL(TOTAL)) u_state (
    .clk(clk), .rst(rst),
    .alloc_hot(alloc_hot), .done_hot(done_hot),
    .state_q(state_q), .state_nx(state_nx)
  );

  for (genvar p = 0; p < N_READ; p++) begin : g_rd
    sb_read_port #(.TOTAL(TOTAL), .TAG_W(TAG_W)) u_port (
      .clk(clk), .rst(rst),
      .vld(rd_vld[p]), .tag(rd_tags[p*TAG_W +: TAG_W]),
      .state_nx(state_nx),
      .ready_q(rd_ready[p]), .bad(rd_bad[p])
    );
  end

  // wakeup and error outputs, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_vec <= '0;
      tag_err  <= 1'b0;
    end else begin
      wake_vec <= done_hot & ~alloc_hot;
      tag_err  <= alloc_bad | done_bad | (|rd_bad);
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int INT_REGS = 96,
  parameter int FP_REGS  = 96,
  parameter int N_READ   = 2,
  localparam int TOTAL   = INT_REGS + FP_REGS,
  localparam int TAG_W   = $clog2(TOTAL)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    alloc_vld,
  input logic [TAG_W-1:0]        alloc_tag,
  input logic                    done_vld,
  input logic [TAG_W-1:0]        done_tag,
  input logic [N_READ-1:0]       rd_vld,
  input logic [N_READ*TAG_W-1:0] rd_tags,
  input logic [N_READ-1:0]       rd_ready,
  input logic [TOTAL-1:0]        wake_vec,
  input logic                    tag_err,
  input logic [TOTAL-1:0]        state_q
);
  localparam logic [TAG_W:0] LIMIT = TOTAL[TAG_W:0];

  logic alloc_ok, done_ok, same_tag;
  assign alloc_ok = alloc_vld && ({1'b0, alloc_tag} < LIMIT);
  assign done_ok  = done_vld  && ({1'b0, done_tag}  < LIMIT);
  assign same_tag = alloc_ok && done_ok && (alloc_tag == done_tag);

  // R2
  a_r2_alloc_clears: assert property (@(posedge clk) disable iff (rst)
    alloc_ok |=> !state_q[$past(alloc_tag)]);

  // R3
  a_r3_done_sets: assert property (@(posedge clk) disable iff (rst)
    (done_ok && !same_tag) |=> state_q[$past(done_tag)]);

  // R4
  a_r4_bypass: assert property (@(posedge clk) disable iff (rst)
    (done_ok && !same_tag && rd_vld[0] && rd_tags[TAG_W-1:0] == done_tag) |=> rd_ready[0]);

  // R5
  a_r5_alloc_wins: assert property (@(posedge clk) disable iff (rst)
    same_tag |=> (wake_vec == '0));

  // R6
  a_r6_wake_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wake_vec));

  a_r6_wake_source: assert property (@(posedge clk) disable iff (rst)
    !done_ok |=> (wake_vec == '0));

  // R7
  a_r7_err_flag: assert property (@(posedge clk) disable iff (rst)
    (alloc_vld && !alloc_ok) |=> tag_err);

  a_r7_no_effect: assert property (@(posedge clk) disable iff (rst)
    (!alloc_ok && !done_ok) |=> $stable(state_q));

  // R8
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_vld[0] |=> !rd_ready[0]);
endmodule

bind phys_reg_scoreboard sb_checker #(
  .INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .N_READ(N_READ)
) u_sb_chk (
  .clk(clk), .rst(rst),
  .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
  .done_vld(done_vld), .done_tag(done_tag),
  .rd_vld(rd_vld), .rd_tags(rd_tags), .rd_ready(rd_ready),
  .wake_vec(wake_vec), .tag_err(tag_err), .state_q(state_q)
);

// File: tb/tb_phys_reg_scoreboard.sv
module tb_phys_reg_scoreboard;
  localparam int INT_REGS = 96;
  localparam int FP_REGS  = 96;
  localparam int N_READ   = 2;
  localparam int TOTAL    = INT_REGS + FP_REGS;
  localparam int TAG_W    = $clog2(TOTAL);

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    alloc_vld = 1'b0;
  logic [TAG_W-1:0]        alloc_tag = '0;
  logic                    done_vld = 1'b0;
  logic [TAG_W-1:0]        done_tag = '0;
  logic [N_READ-1:0]       rd_vld = '0;
  logic [N_READ*TAG_W-1:0] rd_tags = '0;
  logic [N_READ-1:0]       rd_ready;
  logic [TOTAL-1:0]        wake_vec;
  logic                    tag_err;

  int total = 0;
  int bad = 0;
  logic [TOTAL-1:0] model;

  always #4 clk = ~clk;

  phys_reg_scoreboard #(.INT_REGS(INT_REGS), .FP_REGS(FP_REGS), .N_READ(N_READ)) dut (
    .clk(clk), .rst(rst),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .done_vld(done_vld), .done_tag(done_tag),
    .rd_vld(rd_vld), .rd_tags(rd_tags), .rd_ready(rd_ready),
    .wake_vec(wake_vec), .tag_err(tag_err)
  );

  function automatic bit ok_tag(input int t);
    return t < TOTAL;
  endfunction

  task automatic check(input string req, input string what, input logic [TOTAL-1:0] act,
                       input logic [TOTAL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the next posedge
  task automatic step(input string req, input bit av, input int at, input bit dv, input int dt,
                      input bit r0v, input int r0, input bit r1v, input int r1);
    logic [TOTAL-1:0]  nx;
    logic [TOTAL-1:0]  ew;
    logic [N_READ-1:0] er;
    logic              ee;
    alloc_vld = av; alloc_tag = TAG_W'(at);
    done_vld  = dv; done_tag  = TAG_W'(dt);
    rd_vld    = {r1v, r0v};
    rd_tags   = {TAG_W'(r1), TAG_W'(r0)};
    nx = model;
    if (dv && ok_tag(dt)) nx[dt] = 1'b1;
    if (av && ok_tag(at)) nx[at] = 1'b0;
    ew = '0;
    if (dv && ok_tag(dt) && !(av && at == dt)) ew[dt] = 1'b1;
    er[0] = (r0v && ok_tag(r0)) ? nx[r0] : 1'b0;
    er[1] = (r1v && ok_tag(r1)) ? nx[r1] : 1'b0;
    ee = (av && !ok_tag(at)) || (dv && !ok_tag(dt)) ||
         (r0v && !ok_tag(r0)) || (r1v && !ok_tag(r1));
    @(posedge clk); #1;
    model = nx;
    check(req, "rd_ready", TOTAL'(rd_ready), TOTAL'(er));
    check(req, "wake_vec", wake_vec, ew);
    check(req, "tag_err", TOTAL'(tag_err), TOTAL'(ee));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, read first int and first fp tags
    step("R1", 0, 0, 0, 0, 1, 0, 1, INT_REGS);
    step("R1", 0, 0, 0, 0, 1, TOTAL - 1, 1, 5);
    // R2: allocate, then read pending
    step("R2", 1, 10, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 1, 10, 1, 11);
    // R4: allocation seen by a same-cycle read
    step("R4", 1, 20, 0, 0, 1, 20, 0, 0);
    // R3 and R6: completion sets bit and wakes
    step("R3", 0, 0, 1, 10, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 1, 10, 0, 0);
    // R4: completion bypassed to the reader in the same cycle
    step("R4", 0, 0, 1, 20, 1, 20, 1, 20);
    // R5: alloc and completion collide
    step("R5", 1, 100, 1, 100, 1, 100, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 100);
    // R6: wakeup on last valid tag (fp space)
    step("R6", 1, TOTAL - 1, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 1, TOTAL - 1, 0, 0, 1, TOTAL - 1);
    // R7: out-of-range accesses ignored and flagged
    step("R7", 1, TOTAL, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, TOTAL + 3, 1, TOTAL - 64, 0, 0);
    step("R7", 0, 0, 0, 0, 1, TOTAL, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: ports independent, one idle
    step("R8", 1, 33, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 34, 1, 33);
    step("R8", 0, 0, 0, 0, 0, 33, 1, 34);
    // random traffic
    void'($urandom(32'd2718));
    for (int k = 0; k < 3000; k++) begin
      int at = $urandom_range(0, TOTAL + 7);
      int dt = ($urandom_range(0, 3) == 0) ? at : $urandom_range(0, TOTAL + 7);
      int r0 = ($urandom_range(0, 3) == 0) ? dt : $urandom_range(0, TOTAL + 7);
      int r1 = ($urandom_range(0, 3) == 0) ? at : $urandom_range(0, TOTAL + 7);
      step("R8", $urandom_range(0, 1) == 1, at, $urandom_range(0, 1) == 1, dt,
           $urandom_range(0, 3) != 0, r0, $urandom_range(0, 3) != 0, r1);
    end
    // R1: reset returns every tag to ready
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model = '1;
    step("R1", 0, 0, 0, 0, 1, 10, 1, 100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule